// File: doc/BRIEF.md
# Dual-Channel Temperature Limit Alert

This block watches a stream of temperature conversion results and raises an alert on each of two independent channels when the temperature leaves a programmed range. Each result and each limit is a 16-bit word. The signed 14-bit temperature sits in bits 15:2 of the word, with 0.015625 °C per LSB. Bits 1:0 of every word play no part in any comparison. A channel only looks at the result in the cycle that the conversion-done strobe is high.

Each channel has two behaviours, chosen at run time. In window behaviour, a high flag and a low flag latch whichever side was crossed, and an alert latch is set along with them. A configuration-register read clears the flags and the alert. A per-channel clear command clears only that channel's alert. In thermostat behaviour, the high flag and the alert follow a hysteresis loop. They set above the high limit and release below the low limit. The low flag reads 0, and reads and clear commands have no effect. A polarity bit per channel turns the logical alert into the pin level that the open-drain stage will drive.

Top module: `dual_temp_alert`

## Requirements
- R1: After synchronous reset, all flags read 0 and each `alert_lvl` sits at its idle level, which is the inverse of that channel's `pol_high` bit.
- R2: Flags and alerts change only on a cycle with `conv_done`, `cfg_rd` or a `clr_cmd` bit high. Changes on the result or limit inputs alone have no effect.
- R3: In window mode (`thermo_en`=0), a result above the high limit sets `flag_hi` and the alert on the following cycle. Both stay set through later in-range results.
- R4: In window mode, a result below the low limit sets `flag_lo` and the alert, and both stay latched.
- R5: In window mode, a `cfg_rd` pulse clears both flags and the alert of every channel.
- R6: In window mode, `clr_cmd[c]` clears the alert of channel c only. Its flags and the other channel are left unchanged.
- R7: In thermostat mode (`thermo_en`=1), a result above the high limit sets `flag_hi` and the alert. They hold until a conversion result is below the low limit, and then they both clear.
- R8: In thermostat mode, `flag_lo` reads 0, and `cfg_rd` and `clr_cmd` change neither the flag nor the alert.
- R9: `alert_lvl` equals the logical alert when `pol_high`=1 and its inverse when `pol_high`=0. It follows `pol_high` changes in the same cycle.
- R10: Comparisons are strict and signed. A result equal to the high or low limit neither sets nor clears a flag.
- R11: If a conversion that sets a flag arrives in the same cycle as a clearing event, the set wins. A flag that the conversion does not set is still cleared.
- R12: With the high limit at 16'h7FFC and the low limit at 16'h8000, no 14-bit result trips the channel, so `alert_lvl` is set by `pol_high` alone.
- R13: The two channels keep separate state, modes, limits and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: `conv_result` is a new conversion |
| conv_result | input | 16 | Temperature word, signed value in bits 15:2 |
| hi_lim | input | 32 | High limit words, channel c in bits c*16+15:c*16 |
| lo_lim | input | 32 | Low limit words, same packing |
| thermo_en | input | 2 | Per channel: 1 = thermostat, 0 = window |
| pol_high | input | 2 | Per channel: 1 = active-high alert level, 0 = active-low |
| cfg_rd | input | 1 | Configuration-register read strobe |
| clr_cmd | input | 2 | Per-channel alert clear command strobe |
| flag_hi | output | 2 | High flag per channel |
| flag_lo | output | 2 | Low flag per channel |
| alert_lvl | output | 2 | Alert level ahead of the open-drain driver |

## Verification
The assertions assume that `conv_done`, `cfg_rd` and `clr_cmd` are single-cycle events sampled at the clock edge. They also assume that mode and limit inputs are steady in the cycle they govern, and that reset is held for at least one edge. The bench drives every input on the falling edge and returns each strobe to 0 after one cycle. It moves mode, polarity and limits only between events. The sweeps combine conversions with reads and clears in a fixed interleaving, so same-cycle set and clear cases arise along with single events.

// File: rtl/tlim_pkg.sv
`timescale 1ns/1ps
package tlim_pkg;

    typedef enum logic {
        MODE_WINDOW = 1'b0,
        MODE_THERMO = 1'b1
    } tlim_mode_e;

    typedef struct packed {
        logic above;
        logic below;
    } tlim_cmp_t;

    typedef struct packed {
        logic hi;
        logic lo;
        logic alert;
    } tlim_state_t;

    // Next state of one channel given the events sampled this cycle.
    function automatic tlim_state_t tlim_next(
        input tlim_state_t cur,
        input tlim_mode_e  mode,
        input tlim_cmp_t   cmp,
        input logic        conv,
        input logic        cfg_rd,
        input logic        clr
    );
        tlim_state_t nxt;
        logic        set_hi;
        logic        set_lo;
        logic        hot;
        nxt    = cur;
        set_hi = conv & cmp.above;
        set_lo = conv & cmp.below;
        if (mode == MODE_WINDOW) begin
            nxt.hi    = set_hi | (cur.hi & ~cfg_rd);
            nxt.lo    = set_lo | (cur.lo & ~cfg_rd);
            nxt.alert = set_hi | set_lo | (cur.alert & ~(cfg_rd | clr));
        end else if (conv) begin
            if (cmp.above)      hot = 1'b1;
            else if (cmp.below) hot = 1'b0;
            else                hot = cur.hi;
            nxt.hi    = hot;
            nxt.lo    = 1'b0;
            nxt.alert = hot;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tlim_compare.sv
`timescale 1ns/1ps
module tlim_compare
    import tlim_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int TEMP_W = 14
) (
    input  logic [WORD_W-1:0] result_w,
    input  logic [WORD_W-1:0] hi_w,
    input  logic [WORD_W-1:0] lo_w,
    output tlim_cmp_t         cmp
);
    localparam int FRAC_W = WORD_W - TEMP_W;
    localparam logic [WORD_W-1:0] TEMP_MASK = {{TEMP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic signed [WORD_W-1:0] res_s;
    logic signed [WORD_W-1:0] hi_s;
    logic signed [WORD_W-1:0] lo_s;

    always_comb begin
        res_s     = $signed(result_w & TEMP_MASK);
        hi_s      = $signed(hi_w & TEMP_MASK);
        lo_s      = $signed(lo_w & TEMP_MASK);
        cmp.above = (res_s > hi_s);
        cmp.below = (res_s < lo_s);
    end
endmodule

// File: rtl/tlim_channel.sv
`timescale 1ns/1ps
module tlim_channel
    import tlim_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tlim_mode_e  mode,
    input  tlim_cmp_t   cmp,
    input  logic        conv,
    input  logic        cfg_rd,
    input  logic        clr,
    output tlim_state_t st_q
);
    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= tlim_next(st_q, mode, cmp, conv, cfg_rd, clr);
    end

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!conv && !cfg_rd && !clr) |=> $stable(st_q)); // R2

    AST_WIN_STICKY_HI: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WINDOW && st_q.hi && !cfg_rd) |=> st_q.hi); // R3

    AST_WIN_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WINDOW && cfg_rd && !conv) |=> (st_q == '0)); // R5

    AST_THERMO_IGNORES_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_THERMO && !conv) |=> $stable(st_q)); // R8

    AST_THERMO_TRIP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_THERMO && conv && cmp.above) |=> (st_q.hi && st_q.alert)); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WINDOW && conv && cmp.above) |=> (st_q.hi && st_q.alert)); // R11
endmodule

// File: rtl/tlim_drive.sv
`timescale 1ns/1ps
module tlim_drive
    import tlim_pkg::*;
(
    input  tlim_mode_e  mode,
    input  logic        pol_high,
    input  tlim_state_t st,
    output logic        flag_hi,
    output logic        flag_lo,
    output logic        alert_lvl
);
    always_comb begin
        flag_hi   = st.hi;
        flag_lo   = (mode == MODE_THERMO) ? 1'b0 : st.lo;
        alert_lvl = pol_high ? st.alert : ~st.alert;
    end
endmodule

// File: rtl/dual_temp_alert.sv
`timescale 1ns/1ps
module dual_temp_alert
    import tlim_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int WORD_W = 16,
    parameter int TEMP_W = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     conv_done,
    input  logic [WORD_W-1:0]        conv_result,
    input  logic [NUM_CH*WORD_W-1:0] hi_lim,
    input  logic [NUM_CH*WORD_W-1:0] lo_lim,
    input  logic [NUM_CH-1:0]        thermo_en,
    input  logic [NUM_CH-1:0]        pol_high,
    input  logic                     cfg_rd,
    input  logic [NUM_CH-1:0]        clr_cmd,
    output logic [NUM_CH-1:0]        flag_hi,
    output logic [NUM_CH-1:0]        flag_lo,
    output logic [NUM_CH-1:0]        alert_lvl
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tlim_mode_e  mode;
        tlim_cmp_t   cmp;
        tlim_state_t st;

        assign mode = tlim_mode_e'(thermo_en[c]);

        tlim_compare #(.WORD_W(WORD_W), .TEMP_W(TEMP_W)) cmp_i (
            .result_w (conv_result),
            .hi_w     (hi_lim[c*WORD_W +: WORD_W]),
            .lo_w     (lo_lim[c*WORD_W +: WORD_W]),
            .cmp      (cmp)
        );

        tlim_channel ch_i (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode),
            .cmp    (cmp),
            .conv   (conv_done),
            .cfg_rd (cfg_rd),
            .clr    (clr_cmd[c]),
            .st_q   (st)
        );

        tlim_drive drv_i (
            .mode      (mode),
            .pol_high  (pol_high[c]),
            .st        (st),
            .flag_hi   (flag_hi[c]),
            .flag_lo   (flag_lo[c]),
            .alert_lvl (alert_lvl[c])
        );
    end
endmodule

// File: tb/dual_temp_alert_tb.sv
`timescale 1ns/1ps
module dual_temp_alert_tb_top;
    localparam int NCH = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              conv_done;
    logic [15:0]       conv_result;
    logic [NCH*16-1:0] hi_lim;
    logic [NCH*16-1:0] lo_lim;
    logic [NCH-1:0]    thermo_en;
    logic [NCH-1:0]    pol_high;
    logic              cfg_rd;
    logic [NCH-1:0]    clr_cmd;
    logic [NCH-1:0]    flag_hi;
    logic [NCH-1:0]    flag_lo;
    logic [NCH-1:0]    alert_lvl;

    int tests = 0;
    int fails = 0;
    bit m_hi [NCH];
    bit m_lo [NCH];
    bit m_al [NCH];

    always #5 clk = ~clk;

    dual_temp_alert dut_i (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_result(conv_result),
        .hi_lim(hi_lim), .lo_lim(lo_lim), .thermo_en(thermo_en), .pol_high(pol_high),
        .cfg_rd(cfg_rd), .clr_cmd(clr_cmd), .flag_hi(flag_hi), .flag_lo(flag_lo),
        .alert_lvl(alert_lvl)
    );

    function automatic logic [15:0] tw(input int t);
        return 16'(t * 4);
    endfunction

    function automatic int tval(input logic [15:0] w);
        return int'($signed(w[15:2]));
    endfunction

    task automatic chk(input string tag, input int c, input string what,
                       input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s ch%0d %s actual=%b expected=%b", tag, c, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(tag, c, "flag_hi", flag_hi[c], m_hi[c]);
            chk(tag, c, "flag_lo", flag_lo[c], thermo_en[c] ? 1'b0 : m_lo[c]);
            chk(tag, c, "alert_lvl", alert_lvl[c], pol_high[c] ? m_al[c] : ~m_al[c]);
        end
    endtask

    task automatic set_lim(input int c, input logic [15:0] hi, input logic [15:0] lo);
        hi_lim[c*16 +: 16] = hi;
        lo_lim[c*16 +: 16] = lo;
    endtask

    task automatic step(input logic conv, input logic [15:0] res, input logic cfg,
                        input logic [NCH-1:0] clr, input string tag);
        conv_done   = conv;
        conv_result = res;
        cfg_rd      = cfg;
        clr_cmd     = clr;
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            int  t;
            bit  ab;
            bit  be;
            t  = tval(res);
            ab = conv && (t > tval(hi_lim[c*16 +: 16]));
            be = conv && (t < tval(lo_lim[c*16 +: 16]));
            if (!thermo_en[c]) begin
                m_al[c] = ab | be | (m_al[c] & ~(cfg | clr[c]));
                m_hi[c] = ab | (m_hi[c] & ~cfg);
                m_lo[c] = be | (m_lo[c] & ~cfg);
            end else if (conv) begin
                if (ab)      m_hi[c] = 1'b1;
                else if (be) m_hi[c] = 1'b0;
                m_lo[c] = 1'b0;
                m_al[c] = m_hi[c];
            end
        end
        @(negedge clk);
        conv_done = 1'b0;
        cfg_rd    = 1'b0;
        clr_cmd   = '0;
        check_all(tag);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; conv_done = 0; conv_result = '0; cfg_rd = 0; clr_cmd = '0;
        thermo_en = '0; pol_high = '0;
        set_lim(0, tw(1600), tw(0));
        set_lim(1, tw(3200), tw(-3520));
        for (int c = 0; c < NCH; c++) begin m_hi[c] = 0; m_lo[c] = 0; m_al[c] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");
        pol_high = 2'b11; #1;
        check_all("R1");
        pol_high = 2'b00;

        // R2: result and limits move without any strobe
        step(0, tw(5000), 0, 2'b00, "R2");
        set_lim(0, tw(-100), tw(-200));
        step(0, tw(6000), 0, 2'b00, "R2");
        set_lim(0, tw(1600), tw(0));

        // R3 high side latches in window mode
        step(1, tw(1601), 0, 2'b00, "R3");
        step(1, tw(100),  0, 2'b00, "R3");
        // R5 read clears
        step(0, tw(100),  1, 2'b00, "R5");
        // R10 equal to limits does nothing
        step(1, tw(1600), 0, 2'b00, "R10");
        step(1, tw(0),    0, 2'b00, "R10");
        // R4 low side latches
        step(1, tw(-1),   0, 2'b00, "R4");
        step(1, tw(500),  0, 2'b00, "R4");
        // R6 clear command on ch0 only
        step(1, tw(4000), 0, 2'b00, "R13");
        step(0, tw(0),    0, 2'b01, "R6");
        step(0, tw(0),    0, 2'b00, "R6");
        // R11 set wins over same-cycle read and clear
        step(1, tw(2000), 1, 2'b11, "R11");
        // R9 polarity swap
        pol_high = 2'b01; #1; check_all("R9");
        pol_high = 2'b10; #1; check_all("R9");

        // R7 / R8 thermostat on ch1, window on ch0 (R13)
        thermo_en = 2'b10;
        step(0, tw(0),     1, 2'b00, "R13");
        step(1, tw(3201),  0, 2'b00, "R7");
        step(1, tw(0),     0, 2'b00, "R7");
        step(1, tw(-3520), 0, 2'b00, "R7");
        step(0, tw(0),     1, 2'b10, "R8");
        step(1, tw(-4000), 0, 2'b00, "R8");
        step(1, tw(-3521), 0, 2'b00, "R7");
        step(1, tw(3300),  1, 2'b11, "R8");

        // R12 disabled limits
        thermo_en = 2'b00;
        step(0, tw(0), 1, 2'b11, "R12");
        set_lim(0, 16'h7FFC, 16'h8000);
        set_lim(1, 16'h7FFC, 16'h8000);
        step(1, tw(8191),  0, 2'b00, "R12");
        step(1, tw(-8192), 0, 2'b00, "R12");
        thermo_en = 2'b11;
        step(1, tw(8191),  0, 2'b00, "R12");
        pol_high = 2'b01; #1; check_all("R12");

        // Sweep across mode and polarity combinations
        set_lim(0, tw(300),  tw(-300));
        set_lim(1, tw(2000), tw(500));
        for (int cfgi = 0; cfgi < 8; cfgi++) begin
            thermo_en = 2'(cfgi & 3);
            pol_high  = 2'((cfgi >> 1) & 3);
            for (int i = 0; i < 342; i++) begin
                int t;
                t = -8192 + i * 48 + cfgi;
                step((i % 11) != 0, tw(t), (i % 5) == 0,
                     {(i % 7) == 0, (i % 3) == 0}, "SWEEP");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule